// File: doc/BRIEF.md
# Register-Mapped Multiply-Accumulate Unit

A multiplier peripheral that sits on a 16-bit register bus. Software writes the first operand to one of four addresses, and the address chosen fixes the operation: unsigned product, signed product, unsigned accumulate or signed accumulate. Writing the second operand launches the operation. The 2W-bit result register is loaded on that same write edge, so it can be read on the following cycle.

The result is read back as a low word and a high word. An extension word sits beside them and reports the sign of a signed result or the carry out of an unsigned accumulation. Software may write the result words directly, which lets it clear or preload the accumulator before a run of accumulate operations. Reads are combinational from the address.

Top module: `mul_acc_unit`

## Requirements
- R1: After reset, every stored word (first operand, second operand, result low, result high, extension) reads 0, and the mode is unsigned multiply.
- R2: A write to word address 0, 1, 2 or 3 stores the first operand and selects the mode: 0 unsigned multiply, 1 signed multiply, 2 unsigned accumulate, 3 signed accumulate. Reading any of addresses 0 to 3 returns the stored first operand. Address 4 holds the second operand, 5 the result low word, 6 the result high word and 7 the extension word.
- R3: A write to address 4 starts the operation using the stored first operand and the written word. In unsigned multiply mode the result becomes the unsigned product, and the new result can be read from the next cycle.
- R4: In signed multiply mode the result becomes the two's-complement product of both operands.
- R5: In unsigned accumulate mode the unsigned product is added to the previous result. The extension word becomes the carry out of bit 31 of that 32-bit sum, with a value of 0 or 1.
- R6: In signed accumulate mode the signed product is added to the previous result. The extension word becomes 0xFFFF when bit 31 of the sum is set, and 0x0000 otherwise.
- R7: After an operation, the extension word reads 0 in unsigned multiply mode. In signed multiply mode it reads 0xFFFF for a negative product and 0x0000 otherwise.
- R8: Writes to addresses 5 and 6 load the result words directly. A write to address 7 is ignored.
- R9: The result and extension words change only on a second-operand write or, for the result words, on a direct result write. A first-operand write leaves both untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |

## Verification
Directed operand pairs cover the operations most likely to expose errors:
- 0xFFFF times 0xFFFF, run in both unsigned and signed multiply, separates zero extension from sign extension of the operands.
- 0x8000 times 0x8000 and 0x8000 times 0x7FFF probe the most negative operand.
- A preloaded all-ones accumulator checks that the carry is produced in unsigned accumulation and dropped in signed accumulation.

Random sequences with a fixed seed then mix all four modes, preloads and writes to the extension word. They compare the result and extension words against a bench model. This catches a mode latched from the wrong address bit, and accumulation that fails to chain across consecutive operations.

// File: rtl/mul_acc_unit.sv
module mul_acc_unit #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata
);
  localparam int PW = 2 * W;
  localparam logic [AW-1:0] A_OPB = AW'(4);
  localparam logic [AW-1:0] A_RLO = AW'(5);
  localparam logic [AW-1:0] A_RHI = AW'(6);
  localparam logic [AW-1:0] A_EXT = AW'(7);

  typedef enum logic [1:0] {MD_UMUL = 2'd0, MD_SMUL = 2'd1, MD_UMAC = 2'd2, MD_SMAC = 2'd3} mode_t;

  mode_t         mode_q;
  logic [W-1:0]  opa_q, opb_q, ext_q, ext_d;
  logic [PW-1:0] res_q;

  wire sgn = mode_q[0];
  wire acc = mode_q[1];
  wire wr_opa = bus_wr && (bus_addr < A_OPB);
  wire wr_opb = bus_wr && (bus_addr == A_OPB);
  wire wr_rlo = bus_wr && (bus_addr == A_RLO);
  wire wr_rhi = bus_wr && (bus_addr == A_RHI);

  logic signed [W:0]    sa, sb;
  logic signed [PW+1:0] pfull;
  logic [PW:0]          sum;

  assign sa    = {sgn & opa_q[W-1], opa_q};
  assign sb    = {sgn & bus_wdata[W-1], bus_wdata};
  assign pfull = sa * sb;
  assign sum   = {1'b0, (acc ? res_q : {PW{1'b0}})} + {1'b0, pfull[PW-1:0]};

  always_comb begin
    unique case (mode_q)
      MD_UMUL: ext_d = '0;
      MD_UMAC: ext_d = {{(W-1){1'b0}}, sum[PW]};
      default: ext_d = {W{sum[PW-1]}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_UMUL;
      opa_q  <= '0;
      opb_q  <= '0;
      res_q  <= '0;
      ext_q  <= '0;
    end else begin
      if (wr_opa) begin
        opa_q  <= bus_wdata;
        mode_q <= mode_t'(bus_addr[1:0]);
      end
      if (wr_opb) begin
        opb_q <= bus_wdata;
        res_q <= sum[PW-1:0];
        ext_q <= ext_d;
      end
      if (wr_rlo) res_q[W-1:0]  <= bus_wdata;
      if (wr_rhi) res_q[PW-1:W] <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_OPB:   bus_rdata = opb_q;
      A_RLO:   bus_rdata = res_q[W-1:0];
      A_RHI:   bus_rdata = res_q[PW-1:W];
      A_EXT:   bus_rdata = ext_q;
      default: bus_rdata = opa_q;
    endcase
  end

  AST_UMUL_EXT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opb && mode_q == MD_UMUL) |=> (ext_q == '0)); // R7
  AST_SMUL_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opb && mode_q == MD_SMUL) |=> (ext_q == {W{res_q[PW-1]}})); // R7
  AST_UMAC_EXT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opb && mode_q == MD_UMAC) |=> (ext_q[W-1:1] == '0)); // R5
  AST_SMAC_EXT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_opb && mode_q == MD_SMAC) |=> (ext_q == {W{res_q[PW-1]}})); // R6
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_opb || wr_rlo || wr_rhi) |=> $stable(res_q)); // R9
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_opb |=> $stable(ext_q)); // R8
  AST_OPA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_opa |=> (mode_q == mode_t'($past(bus_addr[1:0])))); // R2
endmodule

// File: tb/test_mul_acc_unit.sv
module test_mul_acc_unit;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  int checks = 0, fails = 0;
  logic [1:0]  m_mode;
  logic [15:0] m_opa, m_opb, m_ext;
  logic [31:0] m_res;

  mul_acc_unit i_mul_acc_unit (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata);

  always #2 clk = ~clk;

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  function automatic logic [31:0] prod(input logic [1:0] md, input logic [15:0] a, input logic [15:0] b);
    if (md[0]) return 32'($signed(a) * $signed(b));
    return 32'(a) * 32'(b);
  endfunction

  task automatic model_opb(input logic [15:0] b);
    logic [32:0] s;
    s = {1'b0, (m_mode[1] ? m_res : 32'd0)} + {1'b0, prod(m_mode, m_opa, b)};
    m_opb = b;
    m_res = s[31:0];
    case (m_mode)
      2'd0: m_ext = 16'h0;
      2'd2: m_ext = {15'd0, s[32]};
      default: m_ext = {16{s[31]}};
    endcase
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a < 3'd4) begin m_opa = d; m_mode = a[1:0]; end
    else if (a == 3'd4) model_opb(d);
    else if (a == 3'd5) m_res[15:0] = d;
    else if (a == 3'd6) m_res[31:16] = d;
  endtask

  task automatic chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    bus_wr = 0; bus_addr = a;
    #0.5;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic chk_res(input string tag);
    chk(3'd5, m_res[15:0], tag);
    chk(3'd6, m_res[31:16], tag);
    chk(3'd7, m_ext, tag);
  endtask

  initial begin
    int seed;
    logic [2:0] ra;
    m_mode = 0; m_opa = 0; m_opb = 0; m_ext = 0; m_res = 0;
    seed = $urandom(32'h5eed);
    #9 rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) chk(3'(a), 16'h0, "R1 reset");

    wr(3'd2, 16'h1234);
    for (int a = 0; a < 4; a++) chk(3'(a), 16'h1234, "R2 opa readback");
    wr(3'd0, 16'hFFFF); wr(3'd4, 16'hFFFF);
    chk(3'd4, 16'hFFFF, "R2 opb readback");
    chk_res("R3 umul FFFF*FFFF");
    chk(3'd6, 16'hFFFE, "R7 umul ext zero high");
    wr(3'd1, 16'hFFFF); wr(3'd4, 16'hFFFF); chk_res("R4 smul -1*-1");
    wr(3'd1, 16'h8000); wr(3'd4, 16'h8000); chk_res("R4 smul min*min");
    wr(3'd1, 16'h8000); wr(3'd4, 16'h7FFF); chk_res("R7 smul negative ext");
    chk(3'd7, 16'hFFFF, "R7 ext FFFF");
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF); chk_res("R8 preload");
    wr(3'd7, 16'h5A5A); chk_res("R8 ext write ignored");
    wr(3'd2, 16'h0002); wr(3'd4, 16'h0003); chk_res("R5 umac carry");
    chk(3'd7, 16'h0001, "R5 carry is 1");
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF);
    wr(3'd3, 16'h0002); wr(3'd4, 16'h0003); chk_res("R6 smac wrap");
    chk(3'd7, 16'h0000, "R6 positive sum ext 0");
    wr(3'd3, 16'hFFFF); wr(3'd4, 16'h0010); chk_res("R6 smac negative add");
    wr(3'd0, 16'h7777); chk_res("R9 opa write keeps result");

    for (int i = 0; i < 400; i++) begin
      ra = 3'($urandom_range(0, 7));
      wr(ra, 16'($urandom));
      if (ra == 3'd4) chk_res("R9 random op");
      else if (ra == 3'd7) chk_res("R8 random ext write");
    end
    chk_res("R9 final");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule